// File: doc/BRIEF.md
# Stereo Serial Audio Port

The block moves 16-bit two's-complement audio samples for two channels between parallel sample ports and a bit-serial stereo line. Each sample period on the line is 64 bit-clock periods long. It is split into two 32-bit slots, one per channel. The word clock is high for the channel-1 slot and low for the channel-2 slot. Only 16 of the 32 positions in a slot carry sample bits.

Two static mode inputs apply to both directions at once:
- `pack_front` places the sample at the start or at the end of its slot.
- `msb_first` sends the sample starting from its top bit or from its bottom bit.

The bit clock and word clock come from outside the block. They are inputs sampled in the system clock domain, and their edges are found by comparing each with its value in the previous cycle. The block generates no clocks.

On the receive side, a finished pair is offered for exactly one cycle. The serial line cannot be stalled, so there is no ready signal and the consumer must take the pair in that cycle. On the transmit side, the producer holds `tx_valid` high with a stable pair. A transfer happens only in a cycle where both `tx_valid` and the one-cycle `tx_ready` pulse are high. If no transfer happens at the start of a frame, that frame carries silence (all zeros).

Top module: `audio_serial_port`

## Requirements
- R1: `rx_ch1` and `tx_ch1` belong to the slot in which `wclk` is 1. `rx_ch2` and `tx_ch2` belong to the slot in which `wclk` is 0. Each slot is 32 bit-clock periods long.
- R2: `sdin` is sampled when `bclk` rises. The system clock cycle after the rising edge at position 31 of a channel-2 slot, `rx_valid` is high for exactly one cycle. In that cycle `rx_ch1` and `rx_ch2` hold the pair received in that frame.
- R3: `sdout` changes only after a falling edge of `bclk`. It stays constant while `bclk` is high.
- R4: With `pack_front`=1 the sample occupies slot positions 0 to 15. With `pack_front`=0 it occupies positions 16 to 31. Position 0 is the first bit after the word-clock change.
- R5: With `msb_first`=1 the first data position carries sample bit 15 and the last carries bit 0. With `msb_first`=0 the first carries bit 0 and the last carries bit 15.
- R6: `sdout` is 0 in the 16 slot positions outside the sample. `sdin` values at those positions have no effect on the received pair.
- R7: Every change of `wclk` restarts the slot at position 0. A channel-2 slot that ends before position 31 produces no `rx_valid`. The next full frame is received and sent correctly.
- R8: `tx_ready` is high for one cycle at the start of each channel-1 slot. If `tx_valid` is high in that cycle, the pair on `tx_ch1`/`tx_ch2` is sent in that frame. Otherwise the frame's samples are zero.
- R9: While `clr_n` is 0 at a clock edge, `sdout`, `rx_valid` and `tx_ready` are 0 and slot alignment is lost.
- R10: After reset, the block stays unaligned until it sees a first change of `wclk`. While unaligned, `sdout` is 0 and neither `rx_valid` nor `tx_ready` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Synchronous clear, active low |
| bclk | input | 1 | Bit clock, sampled in the `clk` domain |
| wclk | input | 1 | Word clock: 1 = channel-1 slot, 0 = channel-2 slot |
| sdin | input | 1 | Serial data in |
| sdout | output | 1 | Serial data out |
| pack_front | input | 1 | 1: sample in the first half of the slot; 0: in the second half |
| msb_first | input | 1 | 1: MSB first; 0: LSB first |
| rx_ch1 | output | 16 | Received channel-1 sample |
| rx_ch2 | output | 16 | Received channel-2 sample |
| rx_valid | output | 1 | One-cycle strobe for a received pair |
| tx_ch1 | input | 16 | Channel-1 sample to send |
| tx_ch2 | input | 16 | Channel-2 sample to send |
| tx_valid | input | 1 | Transmit pair is valid |
| tx_ready | output | 1 | Transmit pair is taken this cycle when `tx_valid` is high |

## Verification
The assertions check on every cycle that:
- a word-clock change restarts the slot position;
- `rx_valid` is a single pulse that follows only the last position of a channel-2 slot;
- `tx_ready` is a single pulse;
- `sdout` moves only after a falling bit-clock edge;
- `sdout` is zero while unaligned and outside the sample window.

Three properties need the bench's reference model and its scenarios. These are the bit values placed by each packing and bit-order combination, the pairing of received samples with the right channel, and the silence sent when no transfer happens at a frame start. The bench also shows recovery from a shortened slot and from a clear in the middle of a stream.

// File: rtl/audio_port_pkg.sv
package audio_port_pkg;

  // Map a slot position to a sample bit number, or -1 when the position
  // lies outside the 16-bit sample window.
  function automatic int sample_bit(input int pos, input logic front,
                                    input logic msb, input int sw,
                                    input int slot);
    int k;
    k = front ? pos : pos - (slot - sw);
    if (k < 0 || k >= sw) return -1;
    return msb ? (sw - 1 - k) : k;
  endfunction

endpackage

// File: rtl/slot_tracker.sv
module slot_tracker #(
  parameter int SLOT_W = 32,
  localparam int POS_W = $clog2(SLOT_W) + 1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             edge_i,
  input  logic             wclk_i,
  output logic [POS_W-1:0] pos_o,
  output logic             chan1_o,
  output logic             aligned_o,
  output logic             step_o
);
  // Position saturates at SLOT_W, which is outside every window.
  localparam logic [POS_W-1:0] POS_OVER = POS_W'(SLOT_W);

  logic seen;
  logic last_w;

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      pos_o     <= '0;
      seen      <= 1'b0;
      last_w    <= 1'b0;
      aligned_o <= 1'b0;
      step_o    <= 1'b0;
    end else begin
      step_o <= edge_i;
      if (edge_i) begin
        seen   <= 1'b1;
        last_w <= wclk_i;
        if (seen && (wclk_i != last_w)) begin
          pos_o     <= '0;
          aligned_o <= 1'b1;
        end else if (pos_o != POS_OVER) begin
          pos_o <= pos_o + POS_W'(1);
        end
      end
    end
  end

  assign chan1_o = last_w;

  // R7: a word-clock change seen on a bit edge restarts the slot
  assert_realign_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (edge_i && seen && (wclk_i != last_w)) |=> (pos_o == '0 && aligned_o && step_o));

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import audio_port_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 32,
  localparam int POS_W   = $clog2(SLOT_W) + 1,
  localparam int IDX_W   = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                clr_n,
  input  logic                step,
  input  logic [POS_W-1:0]    pos,
  input  logic                chan1,
  input  logic                aligned,
  input  logic                bit_i,
  input  logic                pack_front,
  input  logic                msb_first,
  output logic [SAMPLE_W-1:0] rx_ch1,
  output logic [SAMPLE_W-1:0] rx_ch2,
  output logic                rx_valid
);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(SLOT_W - 1);

  logic [SAMPLE_W-1:0] buf1, buf2, buf2_nxt;
  logic [IDX_W-1:0]    idx;
  logic                hit, take, done;

  always_comb begin
    int b;
    b   = sample_bit(int'(pos), pack_front, msb_first, SAMPLE_W, SLOT_W);
    hit = (b >= 0);
    idx = hit ? IDX_W'(b) : '0;
  end

  assign take = step && aligned && hit;
  assign done = step && aligned && !chan1 && (pos == POS_LAST);

  always_comb begin
    buf2_nxt = buf2;
    if (take && !chan1) buf2_nxt[idx] = bit_i;
  end

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      buf1     <= '0;
      buf2     <= '0;
      rx_ch1   <= '0;
      rx_ch2   <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (take && chan1) buf1[idx] <= bit_i;
      buf2     <= buf2_nxt;
      rx_valid <= done;
      if (done) begin
        rx_ch1 <= buf1;
        rx_ch2 <= buf2_nxt;
      end
    end
  end

  // R2: the pair strobe is a single cycle
  assert_rx_pulse_R2: assert property (@(posedge clk) disable iff (!clr_n)
    rx_valid |=> !rx_valid);
  // R2: the strobe follows only the last position of a channel-2 slot
  assert_rx_after_slot2_R2: assert property (@(posedge clk) disable iff (!clr_n)
    rx_valid |-> $past(step && !chan1 && pos == POS_LAST));
  // R10: no pair is offered while unaligned
  assert_rx_unaligned_R10: assert property (@(posedge clk) disable iff (!clr_n)
    !aligned |=> !rx_valid);

endmodule

// File: rtl/serial_tx.sv
module serial_tx
  import audio_port_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 32,
  localparam int POS_W   = $clog2(SLOT_W) + 1,
  localparam int IDX_W   = $clog2(SAMPLE_W)
) (
  input  logic                clk,
  input  logic                clr_n,
  input  logic                step,
  input  logic [POS_W-1:0]    pos,
  input  logic                chan1,
  input  logic                aligned,
  input  logic                pack_front,
  input  logic                msb_first,
  input  logic [SAMPLE_W-1:0] tx_ch1,
  input  logic [SAMPLE_W-1:0] tx_ch2,
  input  logic                tx_valid,
  output logic                tx_ready,
  output logic                sdout
);
  logic [SAMPLE_W-1:0] held1, held2, new1, new2, src;
  logic [IDX_W-1:0]    idx;
  logic                hit, load;

  always_comb begin
    int b;
    b   = sample_bit(int'(pos), pack_front, msb_first, SAMPLE_W, SLOT_W);
    hit = (b >= 0);
    idx = hit ? IDX_W'(b) : '0;
  end

  assign load     = step && aligned && chan1 && (pos == '0);
  assign tx_ready = load;
  assign new1     = tx_valid ? tx_ch1 : '0;
  assign new2     = tx_valid ? tx_ch2 : '0;
  assign src      = chan1 ? (load ? new1 : held1) : held2;

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      held1 <= '0;
      held2 <= '0;
      sdout <= 1'b0;
    end else begin
      if (load) begin
        held1 <= new1;
        held2 <= new2;
      end
      if (step) sdout <= (aligned && hit) ? src[idx] : 1'b0;
    end
  end

  // R3: the line moves only on the cycle after a falling-edge step
  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!clr_n)
    !step |=> $stable(sdout));
  // R8: the transfer window is a single cycle
  assert_tx_ready_pulse_R8: assert property (@(posedge clk) disable iff (!clr_n)
    tx_ready |=> !tx_ready);
  // R10: silent line while unaligned
  assert_tx_unaligned_R10: assert property (@(posedge clk) disable iff (!clr_n)
    !aligned |-> !sdout);
  // R6: positions outside the window carry zero once settled
  assert_tx_pad_zero_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (aligned && !step && !hit) |-> !sdout);

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 32,
  localparam int POS_W   = $clog2(SLOT_W) + 1
) (
  input  logic                clk,
  input  logic                clr_n,
  input  logic                bclk,
  input  logic                wclk,
  input  logic                sdin,
  output logic                sdout,
  input  logic                pack_front,
  input  logic                msb_first,
  output logic [SAMPLE_W-1:0] rx_ch1,
  output logic [SAMPLE_W-1:0] rx_ch2,
  output logic                rx_valid,
  input  logic [SAMPLE_W-1:0] tx_ch1,
  input  logic [SAMPLE_W-1:0] tx_ch2,
  input  logic                tx_valid,
  output logic                tx_ready
);
  // Direction index: 0 = receive (rising edges), 1 = transmit (falling edges)
  localparam int NDIR = 2;

  logic             bclk_q;
  logic             sin_hold;
  logic [NDIR-1:0]  edge_v, chan1_v, aligned_v, step_v;
  logic [POS_W-1:0] pos_v [NDIR];

  always_ff @(posedge clk) begin
    if (!clr_n) begin
      bclk_q   <= bclk;
      sin_hold <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (edge_v[0]) sin_hold <= sdin;
    end
  end

  assign edge_v[0] = bclk & ~bclk_q;
  assign edge_v[1] = ~bclk & bclk_q;

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    slot_tracker #(.SLOT_W(SLOT_W)) u_track (
      .clk       (clk),
      .clr_n     (clr_n),
      .edge_i    (edge_v[g]),
      .wclk_i    (wclk),
      .pos_o     (pos_v[g]),
      .chan1_o   (chan1_v[g]),
      .aligned_o (aligned_v[g]),
      .step_o    (step_v[g])
    );
  end

  serial_rx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_rx (
    .clk        (clk),
    .clr_n      (clr_n),
    .step       (step_v[0]),
    .pos        (pos_v[0]),
    .chan1      (chan1_v[0]),
    .aligned    (aligned_v[0]),
    .bit_i      (sin_hold),
    .pack_front (pack_front),
    .msb_first  (msb_first),
    .rx_ch1     (rx_ch1),
    .rx_ch2     (rx_ch2),
    .rx_valid   (rx_valid)
  );

  serial_tx #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_tx (
    .clk        (clk),
    .clr_n      (clr_n),
    .step       (step_v[1]),
    .pos        (pos_v[1]),
    .chan1      (chan1_v[1]),
    .aligned    (aligned_v[1]),
    .pack_front (pack_front),
    .msb_first  (msb_first),
    .tx_ch1     (tx_ch1),
    .tx_ch2     (tx_ch2),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .sdout      (sdout)
  );

  // R9: clear forces the strobes and the line low on the next cycle
  assert_clear_R9: assert property (@(posedge clk)
    !clr_n |=> (!sdout && !rx_valid && !tx_ready));

endmodule

// File: tb/audio_serial_port_bench.sv
module audio_serial_port_bench;
  logic        clk = 1'b0;
  logic        clr_n = 1'b0;
  logic        bclk = 1'b1, wclk = 1'b0, sdin = 1'b0;
  logic        pack_front = 1'b1, msb_first = 1'b1;
  logic [15:0] tx_ch1 = '0, tx_ch2 = '0;
  logic        tx_valid = 1'b0;
  logic        sdout, rx_valid, tx_ready;
  logic [15:0] rx_ch1, rx_ch2;

  int checks = 0, fails = 0, cycles = 0, ready_seen = 0;
  logic [31:0] rx_q[$];

  always #2 clk = ~clk;

  audio_serial_port u_audio_serial_port (
    .clk(clk), .clr_n(clr_n), .bclk(bclk), .wclk(wclk), .sdin(sdin),
    .sdout(sdout), .pack_front(pack_front), .msb_first(msb_first),
    .rx_ch1(rx_ch1), .rx_ch2(rx_ch2), .rx_valid(rx_valid),
    .tx_ch1(tx_ch1), .tx_ch2(tx_ch2), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sample bit number carried at slot position p, or -1 outside the window.
  function automatic int ref_bit(input int p);
    int ws = pack_front ? 0 : 16;
    if (p < ws || p >= ws + 16) return -1;
    return msb_first ? 15 - (p - ws) : (p - ws);
  endfunction

  // Reference model checks on every clock: pair strobe and transfer window
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (tx_ready) ready_seen++;
    if (rx_valid) begin
      if (rx_q.size() == 0) check(0, "R7 R2 unexpected pair", {rx_ch1, rx_ch2}, 0);
      else begin
        logic [31:0] e;
        e = rx_q.pop_front();
        check({rx_ch1, rx_ch2} == e, "R1 R2 R6 received pair", {rx_ch1, rx_ch2}, e);
      end
    end
  end

  // One bit period: fall (drive), check line settled, rise, check stable.
  task automatic send_bit(input logic ch1, input logic din, input logic dout, input string req);
    @(negedge clk);
    bclk = 1'b0; wclk = ch1; sdin = din;
    repeat (4) @(negedge clk);
    check(sdout == dout, req, sdout, dout);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
    check(sdout == dout, "R3 line stable while bclk high", sdout, dout);
  endtask

  task automatic send_slot(input logic ch1, input int len, input logic [15:0] rxw, input logic [15:0] txw);
    for (int p = 0; p < len; p++) begin
      int b = ref_bit(p);
      if (b >= 0) send_bit(ch1, rxw[b], txw[b], "R4 R5 data bit");
      else send_bit(ch1, 1'b1, 1'b0, "R6 pad bit");
    end
  endtask

  task automatic scenario(input logic front, input logic msb, input int short_f, input int off_f);
    @(negedge clk);
    clr_n = 1'b0; bclk = 1'b1; wclk = 1'b0; tx_valid = 1'b0;
    pack_front = front; msb_first = msb;
    repeat (3) @(negedge clk);
    check(sdout == 0 && rx_valid == 0 && tx_ready == 0, "R9 clear state",
          {sdout, rx_valid, tx_ready}, 0);
    clr_n = 1'b1;
    ready_seen = 0;
    for (int i = 0; i < 10; i++) send_bit(1'b0, 1'b1, 1'b0, "R10 unaligned line");
    check(ready_seen == 0, "R10 no transfer while unaligned", ready_seen, 0);
    for (int f = 0; f < 3; f++) begin
      logic [15:0] r1, r2, t1, t2, e1, e2;
      r1 = 16'hA5C3 ^ 16'(f * 16'h0F1E) ^ {front, msb, 14'h0};
      r2 = 16'h3C96 ^ 16'(f * 16'h1357);
      t1 = 16'h8E21 ^ 16'(f * 16'h2468) ^ {14'h0, front, msb};
      t2 = 16'h7049 ^ 16'(f * 16'h1111);
      tx_ch1 = t1; tx_ch2 = t2; tx_valid = (f != off_f);
      e1 = tx_valid ? t1 : 16'h0;
      e2 = tx_valid ? t2 : 16'h0;
      if (f != short_f) rx_q.push_back({r1, r2});
      send_slot(1'b1, 32, r1, e1);
      send_slot(1'b0, (f == short_f) ? 20 : 32, r2, e2);
    end
    check(ready_seen == 3, "R8 one transfer window per frame", ready_seen, 3);
    check(rx_q.size() == 0, "R2 R7 pairs delivered", rx_q.size(), 0);
    rx_q.delete();
  endtask

  initial begin
    scenario(1'b1, 1'b1, -1, 1);
    scenario(1'b0, 1'b1, 1, -1);
    scenario(1'b1, 1'b0, 0, 2);
    scenario(1'b0, 1'b0, 2, 0);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule